// File: doc/BRIEF.md
# Pixel Thermometer Hit Logic

This block is the digital back end of one pixel that sits behind a seven-comparator flash converter. On each rising edge of the bunch-crossing clock it samples the comparator levels. The comparators are active low. Each rising edge closes the comparison half of a period in which the comparators first reset while the clock is high and then compare while it is low. The block counts how many comparators fired to produce a 3-bit amplitude. When anything fired, it latches that amplitude and raises a read request toward the column arbiter.

A two-bit configuration word per pixel is loaded through a serial chain on its own clock. One bit makes the pixel request readout on every crossing even with no charge. The other bit silences the pixel completely. A latched request stays in place, with its amplitude frozen, until the column readout selects the pixel and strobes it. Later hits that arrive while a request is pending are dropped.

Top module: `pixhit_top`

## Requirements
- R1: While `dig_rst` is high, each rising edge of `bx_clk` leaves `read_req` low and `adc_code` zero. Each rising edge of `cfg_clk` clears both configuration bits, so `cfg_out` reads 0 and neither the force bit nor the kill bit is in effect after reset.
- R2: The captured amplitude equals the number of bits of `cmp_n` that are 0, whatever their positions, so bubbles in the thermometer code are tolerated. The range is 0 to 7. Bit i of `cmp_n` is comparator i+1.
- R3: At a rising edge of `bx_clk` where no request is pending, the kill bit is 0 and at least one `cmp_n` bit is 0, `read_req` goes high and `adc_code` shows the R2 amplitude. While `read_req` is low, `adc_code` reads 0.
- R4: Comparator levels count only as they stand at the rising edge of `bx_clk`. A low pulse that lies wholly within the high (reset) half of the clock raises no request.
- R5: While a request is pending, `adc_code` keeps its captured value and further comparator activity or force requests are ignored.
- R6: A pending request clears at a rising edge of `bx_clk` where `pix_sel` and `rd_strobe` are both high. Either signal on its own clears nothing. A new capture cannot happen before the following edge.
- R7: At each rising edge of `cfg_clk`, the configuration word shifts by one place and takes `cfg_in`. `cfg_out` shows the bit that entered two `cfg_clk` edges earlier. After two shifts, the first bit shifted in is the force bit and the second is the kill bit.
- R8: With the force bit 1 and the kill bit 0, an idle pixel raises `read_req` at the next `bx_clk` rising edge even with all comparators high, with amplitude 0. It raises it again at the edge after each clear.
- R9: With the kill bit 1, `read_req` stays low whatever the comparators and the force bit do. A request that is pending when the kill bit is set drops at the next `bx_clk` rising edge, and its amplitude is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bx_clk | input | 1 | Bunch-crossing clock; rising edge samples comparators |
| dig_rst | input | 1 | Synchronous active-high reset for both clock domains |
| cmp_n | input | 7 | Active-low comparator outputs, bit i is comparator i+1 |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_in | input | 1 | Serial configuration data from the previous pixel |
| cfg_out | output | 1 | Serial configuration data to the next pixel |
| pix_sel | input | 1 | Column readout selects this pixel |
| rd_strobe | input | 1 | Column readout strobe |
| read_req | output | 1 | Pending hit, request toward the column arbiter |
| adc_code | output | 3 | Latched amplitude, zero when no request is pending |

## Verification
The hardest state to reach from the ports is a configuration change that lands while a request is pending. The serial word passes through transient values while it shifts, and the kill bit has to arrive between two bunch-crossing edges. The stimulus does the whole two-bit load inside the low half of one `bx_clk` period, so the hit side only ever samples complete words. Then it observes whether the latched value survives, drops or re-arms. All 128 comparator patterns, bubbled codes included, are swept against a popcount that the stimulus computes itself. A glitch confined to the reset half probes the sampling window.

// File: rtl/pixhit_pkg.sv
package pixhit_pkg;

    localparam int PIX_NCMP    = 7;
    localparam int PIX_AMP_W   = 3;
    localparam int PIX_AMP_MAX = (1 << PIX_AMP_W) - 1;

    typedef logic [PIX_AMP_W-1:0] amp_t;

    // Serial word: first shifted bit lands in force_rd, second in kill
    typedef struct packed {
        logic force_rd;
        logic kill;
    } pix_cfg_t;

    localparam int PIX_CFG_BITS = $bits(pix_cfg_t);

    typedef struct packed {
        logic pend;
        amp_t amp;
    } hit_state_t;

    function automatic amp_t clip_amp(input int unsigned n);
        if (n > PIX_AMP_MAX) return amp_t'(PIX_AMP_MAX);
        return amp_t'(n);
    endfunction

endpackage

// File: rtl/pixhit_therm_enc.sv
module pixhit_therm_enc
    import pixhit_pkg::*;
#(
    parameter int NCMP = PIX_NCMP
) (
    input  logic [NCMP-1:0] cmp_n,
    output amp_t            amp,
    output logic            any_hit
);

    int unsigned fired;

    // Count of low comparators; position-free so bubbles do not matter
    always_comb begin
        fired = 0;
        for (int i = 0; i < NCMP; i++) begin
            if (!cmp_n[i]) fired = fired + 1;
        end
        amp = clip_amp(fired);
    end

    assign any_hit = ~&cmp_n;

    // R2
    always_comb begin
        if (!$isunknown(cmp_n)) begin
            enc_consistent_chk: assert (any_hit == (amp != '0));
        end
    end

endmodule

// File: rtl/pixhit_cfg_chain.sv
module pixhit_cfg_chain
    import pixhit_pkg::*;
(
    input  logic     cfg_clk,
    input  logic     rst,
    input  logic     cfg_in,
    output logic     cfg_out,
    output pix_cfg_t cfg
);

    logic [PIX_CFG_BITS-1:0] sh;

    always_ff @(posedge cfg_clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[PIX_CFG_BITS-2:0], cfg_in};
    end

    assign cfg     = pix_cfg_t'(sh);
    assign cfg_out = sh[PIX_CFG_BITS-1];

    // R7
    cfg_passthru_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (cfg_out == $past(cfg_in, 2)));

endmodule

// File: rtl/pixhit_hit_latch.sv
module pixhit_hit_latch
    import pixhit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  amp_t     amp_in,
    input  logic     any_hit,
    input  pix_cfg_t cfg,
    input  logic     pix_sel,
    input  logic     rd_strobe,
    output logic     read_req,
    output amp_t     amp_out
);

    hit_state_t st_q, st_d;
    logic       take_out;
    logic       want_new;

    assign take_out = st_q.pend && pix_sel && rd_strobe;
    assign want_new = any_hit || cfg.force_rd;

    always_comb begin
        st_d = st_q;
        if (cfg.kill || take_out) begin
            st_d = '0;
        end else if (!st_q.pend && want_new) begin
            st_d.pend = 1'b1;
            st_d.amp  = amp_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign read_req = st_q.pend;
    assign amp_out  = st_q.amp;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!read_req && amp_out == '0));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!read_req && !cfg.kill && any_hit) |=> (read_req && amp_out == $past(amp_in)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (read_req && !(pix_sel && rd_strobe) && !cfg.kill) |=> (read_req && $stable(amp_out)));

    // R6
    readout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (read_req && pix_sel && rd_strobe) |=> !read_req);

    // R8
    force_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!read_req && !cfg.kill && cfg.force_rd) |=> read_req);

    // R9
    kill_block_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.kill |=> !read_req);

endmodule

// File: rtl/pixhit_top.sv
module pixhit_top
    import pixhit_pkg::*;
(
    input  logic                 bx_clk,
    input  logic                 dig_rst,
    input  logic [PIX_NCMP-1:0]  cmp_n,
    input  logic                 cfg_clk,
    input  logic                 cfg_in,
    output logic                 cfg_out,
    input  logic                 pix_sel,
    input  logic                 rd_strobe,
    output logic                 read_req,
    output logic [PIX_AMP_W-1:0] adc_code
);

    amp_t     enc_amp;
    logic     enc_hit;
    pix_cfg_t cfg_w;
    amp_t     held_amp;

    pixhit_therm_enc #(.NCMP(PIX_NCMP)) enc_i (
        .cmp_n   (cmp_n),
        .amp     (enc_amp),
        .any_hit (enc_hit)
    );

    pixhit_cfg_chain cfg_i (
        .cfg_clk (cfg_clk),
        .rst     (dig_rst),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .cfg     (cfg_w)
    );

    pixhit_hit_latch hit_i (
        .clk       (bx_clk),
        .rst       (dig_rst),
        .amp_in    (enc_amp),
        .any_hit   (enc_hit),
        .cfg       (cfg_w),
        .pix_sel   (pix_sel),
        .rd_strobe (rd_strobe),
        .read_req  (read_req),
        .amp_out   (held_amp)
    );

    assign adc_code = held_amp;

endmodule

// File: tb/pixhit_top_tb_top.sv
`timescale 1ns/100ps
module pixhit_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cmp_n = '1;
    logic       cfg_clk = 1'b0;
    logic       cfg_in = 1'b0;
    logic       cfg_out;
    logic       sel = 1'b0;
    logic       stb = 1'b0;
    logic       req;
    logic [2:0] code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pixhit_top dut_i (
        .bx_clk    (clk),
        .dig_rst   (rst),
        .cmp_n     (cmp_n),
        .cfg_clk   (cfg_clk),
        .cfg_in    (cfg_in),
        .cfg_out   (cfg_out),
        .pix_sel   (sel),
        .rd_strobe (stb),
        .read_req  (req),
        .adc_code  (code)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string rq, input bit e_req, input int e_code);
        chk(req == e_req, rq, int'(req), int'(e_req));
        chk(int'(code) == e_code, rq, int'(code), e_code);
    endtask

    task automatic cyc(input logic [6:0] c, input logic s, input logic t);
        @(negedge clk);
        cmp_n = c; sel = s; stb = t;
        @(posedge clk);
        #2;
    endtask

    task automatic shift(input logic b);
        cfg_in = b;
        #0.5 cfg_clk = 1'b1;
        #0.5 cfg_clk = 1'b0;
    endtask

    // Whole load inside the low half, then one bx edge with idle inputs
    task automatic load_cfg(input logic f, input logic k);
        @(negedge clk);
        cmp_n = '1; sel = 1'b0; stb = 1'b0;
        shift(f);
        shift(k);
        @(posedge clk);
        #2;
    endtask

    function automatic int lows(input logic [6:0] p);
        int n = 0;
        for (int i = 0; i < 7; i++) if (!p[i]) n++;
        return n;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        shift(1'b1);
        shift(1'b1);
        repeat (2) @(posedge clk);
        #0.2 shift(1'b1);
        #0.2 shift(1'b1);
        #1;
        chk_out("R1", 1'b0, 0);
        chk(cfg_out == 1'b0, "R1", int'(cfg_out), 0);
        @(negedge clk);
        rst = 1'b0;
        cyc('1, 1'b0, 1'b0);
        chk_out("R1", 1'b0, 0);

        // R2 R3 R6 sweep of every comparator pattern
        for (int p = 0; p < 128; p++) begin
            cyc(7'(p), 1'b0, 1'b0);
            if (p == 127) chk_out("R3", 1'b0, 0);
            else          chk_out("R2", 1'b1, lows(7'(p)));
            cyc('1, 1'b1, 1'b1);
            chk_out("R6", 1'b0, 0);
        end

        // R4 glitch confined to the high half
        @(posedge clk);
        #1 cmp_n = '0;
        #2 cmp_n = '1;
        @(posedge clk);
        #2;
        chk_out("R4", 1'b0, 0);

        // R5 hold, R6 partial selects
        cyc(7'b1111110, 1'b0, 1'b0);
        chk_out("R3", 1'b1, 1);
        cyc(7'b0000000, 1'b0, 1'b0);
        chk_out("R5", 1'b1, 1);
        cyc(7'b0101010, 1'b1, 1'b0);
        chk_out("R6", 1'b1, 1);
        cyc(7'b0001111, 1'b0, 1'b1);
        chk_out("R6", 1'b1, 1);
        cyc('1, 1'b1, 1'b1);
        chk_out("R6", 1'b0, 0);

        // R7 serial pass-through (word currently 00)
        @(negedge clk);
        shift(1'b1);
        chk(cfg_out == 1'b0, "R7", int'(cfg_out), 0);
        shift(1'b0);
        chk(cfg_out == 1'b1, "R7", int'(cfg_out), 1);
        shift(1'b1);
        chk(cfg_out == 1'b0, "R7", int'(cfg_out), 0);
        @(posedge clk);
        #2;
        chk_out("R9", 1'b0, 0);
        load_cfg(1'b0, 1'b0);
        chk_out("R7", 1'b0, 0);

        // R8 forced request
        load_cfg(1'b1, 1'b0);
        chk_out("R8", 1'b1, 0);
        chk(cfg_out == 1'b1, "R7", int'(cfg_out), 1);
        cyc(7'b0000000, 1'b0, 1'b0);
        chk_out("R5", 1'b1, 0);
        cyc('1, 1'b1, 1'b1);
        chk_out("R6", 1'b0, 0);
        cyc('1, 1'b0, 1'b0);
        chk_out("R8", 1'b1, 0);
        cyc('1, 1'b1, 1'b1);
        chk_out("R6", 1'b0, 0);
        load_cfg(1'b0, 1'b0);
        chk_out("R8", 1'b0, 0);

        // R9 kill
        load_cfg(1'b1, 1'b1);
        chk_out("R9", 1'b0, 0);
        cyc(7'b0000000, 1'b0, 1'b0);
        chk_out("R9", 1'b0, 0);
        cyc('1, 1'b0, 1'b0);
        chk_out("R9", 1'b0, 0);
        load_cfg(1'b0, 1'b0);
        chk_out("R9", 1'b0, 0);
        cyc(7'b0011111, 1'b0, 1'b0);
        chk_out("R3", 1'b1, 2);
        load_cfg(1'b0, 1'b1);
        chk_out("R9", 1'b0, 0);
        load_cfg(1'b0, 1'b0);
        chk_out("R9", 1'b0, 0);

        // R1 reset while pending, config cleared too
        load_cfg(1'b1, 1'b0);
        chk_out("R8", 1'b1, 0);
        @(negedge clk);
        rst = 1'b1;
        shift(1'b1);
        @(posedge clk);
        #2;
        chk_out("R1", 1'b0, 0);
        chk(cfg_out == 1'b0, "R1", int'(cfg_out), 0);
        @(negedge clk);
        rst = 1'b0;
        cyc('1, 1'b0, 1'b0);
        chk_out("R1", 1'b0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule